// File: doc/BRIEF.md
# Bank Decoder with Write Shadowing

This block sits beside the CPU of a machine with a 24-bit address: an 8-bit bank number above a 16-bit offset. For every access it picks one target. The target is the I/O window, the bank-switched upper region, or plain RAM. The choice depends on the bank, on the offset and on one enable bit in a control register.

Fast RAM banks are $00 to $7F. When a write to such a bank lands in one of five video regions, the block also raises a shadow-write strobe. It names the slow bank, $E0 or $E1, that must receive a copy of the data. The copy uses the same offset as the original write.

Two 8-bit control registers sit behind a small register port. The shadow register holds one inhibit bit per video region and the I/O enable bit. The speed register holds the bit that extends shadowing to all fast banks. Decode and shadow outputs are combinational from the access inputs. Only the two control registers are clocked.

Top module: `bank_shadow_dec`

## Requirements
- R1: In banks $E0 and $E1, offsets $C000–$CFFF always select I/O (io_sel_o), and offsets $D000–$FFFF always select the upper region (uc_sel_o).
- R2: In banks $00 and $01, the I/O window and the upper region are decoded only when shadow-register bit 6 is 1. When that bit is 0, those offsets select RAM.
- R3: In every bank other than $00, $01, $E0 and $E1, every offset selects RAM.
- R4: Whenever uc_sel_o is high, uc_dx_o is 1 for offsets $D000–$DFFF and 0 for $E000–$FFFF. uc_dx_o is 0 whenever uc_sel_o is low.
- R5: When valid_i is high, exactly one of io_sel_o, uc_sel_o and ram_sel_o is high. When valid_i is low, all three are low.
- R6: shadow_we_o is high only for a valid RAM write (we_i=1) that hits an uninhibited region in an eligible bank. It is never high on a read. When shadow_we_o is low, shadow_bank_o reads $00.
- R7: The video regions are indexed by their shadow-register bits:
  - bit 0: $0400–$07FF
  - bit 1: $2000–$3FFF
  - bit 2: $4000–$5FFF
  - bit 3: $2000–$9FFF
  - bit 4: $0800–$0BFF

  A bit value of 1 inhibits its region and 0 enables it. A write that hits any enabled region is shadowed.
- R8: Banks $00 and $01 are always eligible for shadowing. When speed-register bit 4 is 1, every bank $00–$7F is eligible. Banks $80–$FF are never eligible. Speed bit 4 does not extend the I/O decode of R2 to other banks.
- R9: A shadowed write from an even bank targets $E0, and one from an odd bank targets $E1.
- R10: After reset, the shadow register reads $40 and the speed register reads $00.
- R11: reg_sel_i=0 addresses the shadow register and reg_sel_i=1 addresses the speed register. A write with reg_wr_i high takes effect at the next clock edge. Reads are combinational. Only bits 0–4 and 6 of the shadow register and bit 4 of the speed register are stored; all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | CPU access present |
| we_i | input | 1 | Access is a write |
| addr_i | input | 24 | Bank (23:16) and offset (15:0) |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_sel_i | input | 1 | 0 selects the shadow register, 1 selects the speed register |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Selected control register, masked |
| io_sel_o | output | 1 | Access hits the I/O window |
| uc_sel_o | output | 1 | Access hits the upper region |
| uc_dx_o | output | 1 | Upper-region access is in the $D000–$DFFF sub-range |
| ram_sel_o | output | 1 | Access goes to plain RAM |
| shadow_we_o | output | 1 | Mirror this write into a slow bank |
| shadow_bank_o | output | 8 | Slow bank to receive the mirrored write |

## Verification
The bench sends accesses to banks $00, $01, $E0 and $E1, to mid-range fast banks and to banks at $80 and above. It does this with the I/O enable bit both set and cleared, which separates decode that always applies from decode that depends on the enable bit.

Offsets are pushed onto the exact start and end of each video region and of the $C000 and $D000 sub-ranges. Off-by-one range errors then show up as a wrong select or a wrong shadow strobe.

Reads paired with writes at the same address show whether shadowing checks the write direction. Random register values mixed into the stream exercise each inhibit bit and the all-banks bit alone and together, which tells a per-region gating error apart from a bank-eligibility error.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
  parameter int NUM_RGN      = 5;
  parameter int IO_EN_BIT    = 6;
  parameter int ALL_BANK_BIT = 4;
  parameter logic [7:0] SHD_MASK = 8'h5F;
  parameter logic [7:0] SPD_MASK = 8'h10;
  parameter logic [7:0] SHD_RST  = 8'h40;
  parameter logic [7:0] SPD_RST  = 8'h00;
  parameter logic [7:0] SLOW_EVEN = 8'hE0;

  typedef logic [7:0]  bank_t;
  typedef logic [15:0] off_t;

  typedef struct packed {
    off_t lo;
    off_t hi;
  } rgn_t;

  function automatic rgn_t rgn_of(int idx);
    rgn_t r;
    case (idx)
      0:       r = '{lo: 16'h0400, hi: 16'h07FF};
      1:       r = '{lo: 16'h2000, hi: 16'h3FFF};
      2:       r = '{lo: 16'h4000, hi: 16'h5FFF};
      3:       r = '{lo: 16'h2000, hi: 16'h9FFF};
      default: r = '{lo: 16'h0800, hi: 16'h0BFF};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bank_ctl_regs.sv
module bank_ctl_regs
  import bank_dec_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] shd_o,
  output logic [DW-1:0] spd_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] shd_q, spd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= DW'(SHD_RST);
      spd_q <= DW'(SPD_RST);
    end else if (wr_i) begin
      if (sel_i) spd_q <= wdata_i & DW'(SPD_MASK);
      else       shd_q <= wdata_i & DW'(SHD_MASK);
    end
  end

  assign shd_o   = shd_q;
  assign spd_o   = spd_q;
  assign rdata_o = sel_i ? spd_q : shd_q;
endmodule

// File: rtl/bank_addr_decode.sv
module bank_addr_decode
  import bank_dec_pkg::*;
(
  input  logic  valid_i,
  input  bank_t bank_i,
  input  off_t  off_i,
  input  logic  io_en_i,
  output logic  io_sel_o,
  output logic  uc_sel_o,
  output logic  uc_dx_o,
  output logic  ram_sel_o
);
  logic slow_sys, fast_sys, sys_bank, in_io, in_uc;

  always_comb begin
    slow_sys  = (bank_i[7:1] == 7'h70);
    fast_sys  = (bank_i[7:1] == 7'h00) && io_en_i;
    sys_bank  = slow_sys || fast_sys;
    in_io     = (off_i[15:12] == 4'hC);
    in_uc     = (off_i[15:12] >= 4'hD);
    io_sel_o  = valid_i && sys_bank && in_io;
    uc_sel_o  = valid_i && sys_bank && in_uc;
    uc_dx_o   = uc_sel_o && (off_i[15:12] == 4'hD);
    ram_sel_o = valid_i && !(sys_bank && (in_io || in_uc));
  end
endmodule

// File: rtl/bank_shadow_gen.sv
module bank_shadow_gen
  import bank_dec_pkg::*;
#(
  parameter int NR = NUM_RGN
) (
  input  logic          valid_i,
  input  logic          we_i,
  input  logic          ram_sel_i,
  input  bank_t         bank_i,
  input  off_t          off_i,
  input  logic [NR-1:0] inhibit_i,
  input  logic          all_banks_i,
  output logic          shadow_we_o,
  output bank_t         shadow_bank_o
);
  logic [NR-1:0] hit;
  logic eligible;

  for (genvar g = 0; g < NR; g++) begin : g_rgn
    localparam rgn_t R = rgn_of(g);
    assign hit[g] = !inhibit_i[g] && (off_i >= R.lo) && (off_i <= R.hi);
  end

  always_comb begin
    eligible      = (bank_i[7:1] == 7'h00) || (all_banks_i && !bank_i[7]);
    shadow_we_o   = valid_i && we_i && ram_sel_i && eligible && (|hit);
    shadow_bank_o = shadow_we_o ? (SLOW_EVEN | bank_t'(bank_i[0])) : '0;
  end
endmodule

// File: rtl/bank_shadow_dec.sv
module bank_shadow_dec
  import bank_dec_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic        we_i,
  input  logic [23:0] addr_i,
  input  logic        reg_wr_i,
  input  logic        reg_sel_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  output logic        io_sel_o,
  output logic        uc_sel_o,
  output logic        uc_dx_o,
  output logic        ram_sel_o,
  output logic        shadow_we_o,
  output logic [7:0]  shadow_bank_o
);
  logic [7:0] shd, spd;
  bank_t bank;
  off_t  off;

  assign bank = addr_i[23:16];
  assign off  = addr_i[15:0];

  bank_ctl_regs #(.DW(8)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .shd_o   (shd),
    .spd_o   (spd),
    .rdata_o (reg_rdata_o)
  );

  bank_addr_decode u_dec (
    .valid_i   (valid_i),
    .bank_i    (bank),
    .off_i     (off),
    .io_en_i   (shd[IO_EN_BIT]),
    .io_sel_o  (io_sel_o),
    .uc_sel_o  (uc_sel_o),
    .uc_dx_o   (uc_dx_o),
    .ram_sel_o (ram_sel_o)
  );

  bank_shadow_gen #(.NR(NUM_RGN)) u_shd (
    .valid_i       (valid_i),
    .we_i          (we_i),
    .ram_sel_i     (ram_sel_o),
    .bank_i        (bank),
    .off_i         (off),
    .inhibit_i     (shd[NUM_RGN-1:0]),
    .all_banks_i   (spd[ALL_BANK_BIT]),
    .shadow_we_o   (shadow_we_o),
    .shadow_bank_o (shadow_bank_o)
  );
endmodule

// File: rtl/bank_shadow_dec_chk.sv
module bank_shadow_dec_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        we_i,
  input logic [23:0] addr_i,
  input logic        io_sel_o,
  input logic        uc_sel_o,
  input logic        uc_dx_o,
  input logic        ram_sel_o,
  input logic        shadow_we_o,
  input logic [7:0]  shadow_bank_o
);
  logic [7:0] bk;
  assign bk = addr_i[23:16];

  p_slow_io_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bk[7:1] == 7'h70 && addr_i[15:12] == 4'hC) |-> io_sel_o);

  p_other_ram_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bk[7:1] != 7'h70 && bk[7:1] != 7'h00) |-> ram_sel_o);

  p_dx_in_uc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uc_dx_o |-> uc_sel_o);

  p_onehot_sel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({io_sel_o, uc_sel_o, ram_sel_o}));

  p_valid_sel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (io_sel_o || uc_sel_o || ram_sel_o));

  p_no_read_shadow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |-> !shadow_we_o);

  p_idle_bank_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shadow_we_o |-> (shadow_bank_o == 8'h00));

  p_fast_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shadow_we_o |-> !addr_i[23]);

  p_target_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shadow_we_o |-> (shadow_bank_o[7:1] == 7'h70 && shadow_bank_o[0] == addr_i[16]));
endmodule

bind bank_shadow_dec bank_shadow_dec_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .valid_i       (valid_i),
  .we_i          (we_i),
  .addr_i        (addr_i),
  .io_sel_o      (io_sel_o),
  .uc_sel_o      (uc_sel_o),
  .uc_dx_o       (uc_dx_o),
  .ram_sel_o     (ram_sel_o),
  .shadow_we_o   (shadow_we_o),
  .shadow_bank_o (shadow_bank_o)
);

// File: tb/bank_shadow_dec_bench.sv
`timescale 1ns/1ps
module bank_shadow_dec_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        valid_i = 1'b0, we_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic        reg_wr_i = 1'b0, reg_sel_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o, shadow_bank_o;
  logic        io_sel_o, uc_sel_o, uc_dx_o, ram_sel_o, shadow_we_o;

  int n_vec = 0, n_err = 0;
  bit done = 1'b0;
  logic [7:0] m_shd = 8'h40, m_spd = 8'h00;

  always #4 clk_i = ~clk_i;

  bank_shadow_dec u_bank_shadow_dec (.*);

  function automatic bit in_rng(logic [15:0] o, logic [15:0] lo, logic [15:0] hi);
    return (o >= lo) && (o <= hi);
  endfunction

  // bench reference model, from the requirements
  function automatic bit sys_vis(logic [7:0] b);
    return (b == 8'hE0 || b == 8'hE1) || ((b == 8'h00 || b == 8'h01) && m_shd[6]);
  endfunction
  function automatic bit e_io(logic v, logic [7:0] b, logic [15:0] o);
    return v && sys_vis(b) && in_rng(o, 16'hC000, 16'hCFFF);
  endfunction
  function automatic bit e_uc(logic v, logic [7:0] b, logic [15:0] o);
    return v && sys_vis(b) && o >= 16'hD000;
  endfunction
  function automatic bit e_shw(logic v, logic w, logic [7:0] b, logic [15:0] o);
    bit elig, hit;
    elig = (b <= 8'h01) || (m_spd[4] && b <= 8'h7F);
    hit  = (!m_shd[0] && in_rng(o, 16'h0400, 16'h07FF)) ||
           (!m_shd[1] && in_rng(o, 16'h2000, 16'h3FFF)) ||
           (!m_shd[2] && in_rng(o, 16'h4000, 16'h5FFF)) ||
           (!m_shd[3] && in_rng(o, 16'h2000, 16'h9FFF)) ||
           (!m_shd[4] && in_rng(o, 16'h0800, 16'h0BFF));
    return v && w && elig && hit && !e_io(v, b, o) && !e_uc(v, b, o);
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s addr=%06h we=%0b: got %02h expected %02h",
               tag, what, addr_i, we_i, act, exp);
    end
  endtask

  task automatic access(logic v, logic w, logic [7:0] b, logic [15:0] o);
    bit eio, euc, esw;
    @(negedge clk_i);
    valid_i = v; we_i = w; addr_i = {b, o};
    #1;
    eio = e_io(v, b, o);
    euc = e_uc(v, b, o);
    esw = e_shw(v, w, b, o);
    chk((b[7:1] == 7'h70) ? "R1" : (b[7:1] == 7'h00) ? "R2" : "R3",
        "io_sel", 8'(io_sel_o), 8'(eio));
    chk("R4", "uc_sel", 8'(uc_sel_o), 8'(euc));
    chk("R4", "uc_dx", 8'(uc_dx_o), 8'(euc && o[15:12] == 4'hD));
    chk("R5", "ram_sel", 8'(ram_sel_o), 8'(v && !eio && !euc));
    chk((b > 8'h01) ? "R8" : "R7", "shadow_we", 8'(shadow_we_o), 8'(esw));
    chk("R9", "shadow_bank", shadow_bank_o, esw ? (b[0] ? 8'hE1 : 8'hE0) : 8'h00);
  endtask

  task automatic wreg(logic s, logic [7:0] d);
    @(negedge clk_i);
    valid_i = 1'b0; reg_wr_i = 1'b1; reg_sel_i = s; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
    if (s) m_spd = d & 8'h10; else m_shd = d & 8'h5F;
    #1;
    chk("R11", "readback", reg_rdata_o, s ? m_spd : m_shd);
  endtask

  task automatic rreg(string tag, logic s);
    @(negedge clk_i);
    reg_sel_i = s;
    #1;
    chk(tag, "readback", reg_rdata_o, s ? m_spd : m_shd);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] edges [16];
    logic [7:0]  banks [8];
    edges = '{16'h03FF, 16'h0400, 16'h07FF, 16'h0800, 16'h0BFF, 16'h0C00,
              16'h1FFF, 16'h2000, 16'h5FFF, 16'h9FFF, 16'hA000, 16'hBFFF,
              16'hC000, 16'hCFFF, 16'hD000, 16'hE000};
    banks = '{8'h00, 8'h01, 8'hE0, 8'hE1, 8'h02, 8'h7F, 8'h80, 8'h3A};
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk_i);
    rst_ni = 1'b1;
    rreg("R10", 1'b0);
    rreg("R10", 1'b1);

    // directed corners
    access(1, 0, 8'hE0, 16'hC000);
    access(1, 1, 8'hE1, 16'hCFFF);
    access(1, 0, 8'h00, 16'hD000);   // R4 sub-range start
    access(1, 0, 8'h01, 16'hDFFF);
    access(1, 0, 8'h00, 16'hE000);
    access(0, 1, 8'h00, 16'h2000);   // R5 idle
    access(1, 1, 8'h00, 16'h2000);   // R6 shadowed write
    access(1, 0, 8'h00, 16'h2000);   // R6 read never shadows
    access(1, 1, 8'h01, 16'h9FFF);
    access(1, 1, 8'h01, 16'hA000);
    access(1, 1, 8'h02, 16'h2000);   // R8 not eligible
    wreg(1'b0, 8'hFF);               // R11 masked
    access(1, 1, 8'h00, 16'h2000);   // R7 all inhibited
    access(1, 0, 8'h00, 16'hC000);
    wreg(1'b0, 8'h00);
    access(1, 0, 8'h00, 16'hC000);   // R2 hidden
    access(1, 1, 8'h01, 16'hD800);
    wreg(1'b1, 8'hFF);
    access(1, 1, 8'h02, 16'h0400);   // R8 extended
    access(1, 0, 8'h02, 16'hC000);   // R8 io not extended
    access(1, 1, 8'h7F, 16'h0BFF);
    access(1, 1, 8'h80, 16'h2000);
    wreg(1'b0, 8'h08);               // R7 only bit 3 inhibited
    access(1, 1, 8'h00, 16'h3000);
    access(1, 1, 8'h00, 16'h6000);

    // constrained random
    for (int i = 0; i < 1500; i++) begin
      int k;
      logic [7:0] b;
      logic [15:0] o;
      k = int'($urandom_range(0, 19));
      if (k == 0) begin
        wreg(1'($urandom_range(0, 1)), 8'($urandom));
      end else begin
        b = ($urandom_range(0, 3) == 0) ? 8'($urandom) : banks[$urandom_range(0, 7)];
        o = ($urandom_range(0, 1) == 0) ? edges[$urandom_range(0, 15)] : 16'($urandom);
        access(1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)), b, o);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule